// File: doc/BRIEF.md
# Nine-Bit Multi-Cycle Register Machine

This block is a very small processor core. Both its instructions and its data words are nine bits wide. It has four general registers and uses a sixteen-word external memory that holds the program as well as its data. After reset it fetches from address 0 and steps through the words one at a time. Each word carries a three-bit operation code and either three two-bit register fields or one register field with a four-bit memory address. Two of the memory addresses do not reach storage. Address 14 returns the value on the input bus, and address 15 sends a value to the output bus.

The core reaches memory through a single synchronous port. It drives an address, and read data comes back one clock later. A write happens at the clock edge during which the write enable is high. Values sent to the output bus appear on a registered output together with a one-cycle strobe. When the core fetches an all-zero word it stops and raises `halted`, and it stays stopped until the next reset.

Top module: `tiny9_cpu`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `memAddr` is 0, and `halted`, `outStrobe` and `memWe` are 0. All four registers and the program counter read as zero after reset.
- R2: The operation code is bits [8:6]: 000 subtract, 001 add, 010 load, 011 store, 100 read input, 101 write output, 110 jump, 111 branch if non-zero.
- R3: Subtract and add write reg[8:6-decoded bits 5:4] = reg[bits 3:2] minus or plus reg[bits 1:0], modulo 512, and set no flags. Field value 00 selects R0, which works like any other register.
- R4: Load puts the memory word at address bits [3:0] into the register named by bits [5:4]. When the address is 14, the register receives the input bus value instead.
- R5: Store writes the register named by bits [5:4] to the memory address in bits [3:0]. When the address is 15, the value goes to `outPort` with a one-cycle `outStrobe`, and memory is not written.
- R6: Read copies the input bus into the register named by bits [5:4]. Write sends that register to `outPort` with a one-cycle `outStrobe`. Both ignore bits [3:0].
- R7: Jump loads the program counter from bits [3:0]. Branch loads it from bits [3:0] only if the register named by bits [5:4] is non-zero, and otherwise moves on to the next word.
- R8: Every instruction other than a taken jump or branch advances the 4-bit program counter by one, and the counter wraps from 15 to 0.
- R9: Fetching an all-zero word sets `halted`. It stays set, and no further memory write or output strobe happens until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 4 | Memory word address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 9 | Memory write data |
| memRdata | input | 9 | Memory read data, valid one cycle after the address |
| inPort | input | 9 | Input bus value |
| outPort | output | 9 | Last value sent to the output |
| outStrobe | output | 1 | One-cycle pulse when `outPort` is updated |
| halted | output | 1 | High once an all-zero word has been fetched |

## Verification
Registers are visible only through Write or port stores, so every program ends by dumping all four registers to the output. Wrap-around of the program counter from 15 to 0 is the hardest case to reach, because straight-line code halts long before address 15. A directed program therefore jumps to word 15. That word writes a register, the counter wraps, and the core re-enters word 0, where a branch is now taken because of a register that was filled on the first pass. Random programs use forward-only jumps so that they always terminate. Their stores go only to 13 and 15, so that the reference model and the core execute the same words.

// File: rtl/tiny9_pkg.sv
package tiny9_pkg;
  localparam int WORD_W    = 9;
  localparam int ADDR_W    = 4;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int OP_W      = WORD_W - 2 * REG_IDX_W - REG_IDX_W;
  localparam logic [ADDR_W-1:0] IN_ADDR  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] OUT_ADDR = ADDR_W'(15);

  typedef enum logic [OP_W-1:0] {
    OP_SUB = 3'b000, OP_ADD = 3'b001, OP_LOAD = 3'b010, OP_STORE = 3'b011,
    OP_READ = 3'b100, OP_WRITE = 3'b101, OP_GOTO = 3'b110, OP_BRIF = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {WR_ALU = 2'd0, WR_IN = 2'd1, WR_MEM = 2'd2} wrsrc_e;

  typedef struct packed {
    logic   irLoad;
    logic   regWe;
    wrsrc_e wrSrc;
    logic   pcInc;
    logic   pcLoad;
    logic   addrSel;
    logic   memWe;
    logic   outLoad;
  } ctrl_t;
endpackage

// File: rtl/tiny9_datapath.sv
module tiny9_datapath
  import tiny9_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] inPort,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output opcode_e           opcode,
  output logic [ADDR_W-1:0] fieldAddr,
  output logic              regNonZero,
  output logic [WORD_W-1:0] outPort,
  output logic              outStrobe
);
  logic [ADDR_W-1:0]    pc;
  logic [WORD_W-1:0]    ir;
  logic [WORD_W-1:0]    regFile [NUM_REGS];
  logic [REG_IDX_W-1:0] dstIdx, srcAIdx, srcBIdx;
  logic [WORD_W-1:0]    regD, regA, regB, aluRes, wrData;

  assign opcode    = opcode_e'(ir[WORD_W-1 -: OP_W]);
  assign dstIdx    = ir[2*REG_IDX_W +: REG_IDX_W];
  assign srcAIdx   = ir[REG_IDX_W +: REG_IDX_W];
  assign srcBIdx   = ir[0 +: REG_IDX_W];
  assign fieldAddr = ir[ADDR_W-1:0];

  assign regD = regFile[dstIdx];
  assign regA = regFile[srcAIdx];
  assign regB = regFile[srcBIdx];
  assign regNonZero = |regD;

  assign aluRes = (opcode == OP_ADD) ? regA + regB : regA - regB;

  always_comb begin
    case (ctl.wrSrc)
      WR_IN:   wrData = inPort;
      WR_MEM:  wrData = memRdata;
      default: wrData = aluRes;
    endcase
  end

  assign memAddr  = ctl.addrSel ? fieldAddr : pc;
  assign memWdata = regD;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (ctl.irLoad) ir <= memRdata;
      if (ctl.pcLoad)     pc <= fieldAddr;
      else if (ctl.pcInc) pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst) regFile[i] <= '0;
      else if (ctl.regWe && dstIdx == REG_IDX_W'(i)) regFile[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outPort   <= '0;
      outStrobe <= 1'b0;
    end else begin
      outStrobe <= ctl.outLoad;
      if (ctl.outLoad) outPort <= regD;
    end
  end

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc && !ctl.pcLoad |=> pc == $past(pc) + ADDR_W'(1));

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> !outStrobe);

  // R5
  port_store_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.memWe |-> memAddr != OUT_ADDR);
endmodule

// File: rtl/tiny9_control.sv
module tiny9_control
  import tiny9_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opcode_e           opcode,
  input  logic [ADDR_W-1:0] fieldAddr,
  input  logic              regNonZero,
  input  logic [WORD_W-1:0] memRdata,
  output ctrl_t             ctl,
  output logic              halted
);
  typedef enum logic [2:0] {S_FETCH, S_LATCH, S_EXEC, S_MEMRD, S_HALT} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= stateNext;
  end

  assign halted = (state == S_HALT);

  always_comb begin
    ctl       = '0;
    ctl.wrSrc = WR_ALU;
    stateNext = state;
    case (state)
      S_FETCH: stateNext = S_LATCH;
      S_LATCH: begin
        ctl.irLoad = 1'b1;
        stateNext  = (memRdata == '0) ? S_HALT : S_EXEC;
      end
      S_EXEC: begin
        stateNext = S_FETCH;
        case (opcode)
          OP_SUB, OP_ADD: begin
            ctl.regWe = 1'b1;
            ctl.pcInc = 1'b1;
          end
          OP_LOAD: begin
            ctl.addrSel = 1'b1;
            if (fieldAddr == IN_ADDR) begin
              ctl.regWe = 1'b1;
              ctl.wrSrc = WR_IN;
              ctl.pcInc = 1'b1;
            end else begin
              stateNext = S_MEMRD;
            end
          end
          OP_STORE: begin
            ctl.addrSel = 1'b1;
            ctl.pcInc   = 1'b1;
            if (fieldAddr == OUT_ADDR) ctl.outLoad = 1'b1;
            else                       ctl.memWe   = 1'b1;
          end
          OP_READ: begin
            ctl.regWe = 1'b1;
            ctl.wrSrc = WR_IN;
            ctl.pcInc = 1'b1;
          end
          OP_WRITE: begin
            ctl.outLoad = 1'b1;
            ctl.pcInc   = 1'b1;
          end
          OP_GOTO: ctl.pcLoad = 1'b1;
          OP_BRIF: begin
            if (regNonZero) ctl.pcLoad = 1'b1;
            else            ctl.pcInc  = 1'b1;
          end
          default: ctl.pcInc = 1'b1;
        endcase
      end
      S_MEMRD: begin
        ctl.regWe = 1'b1;
        ctl.wrSrc = WR_MEM;
        ctl.pcInc = 1'b1;
        stateNext = S_FETCH;
      end
      default: stateNext = S_HALT;
    endcase
  end

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ctl.memWe && !ctl.outLoad && !ctl.regWe);

  // R4
  memrd_order_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_MEMRD |-> $past(state) == S_EXEC);
endmodule

// File: rtl/tiny9_cpu.sv
module tiny9_cpu
  import tiny9_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] inPort,
  output logic [WORD_W-1:0] outPort,
  output logic              outStrobe,
  output logic              halted
);
  ctrl_t             ctl;
  opcode_e           opcode;
  logic [ADDR_W-1:0] fieldAddr;
  logic              regNonZero;

  tiny9_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .fieldAddr  (fieldAddr),
    .regNonZero (regNonZero),
    .memRdata   (memRdata),
    .ctl        (ctl),
    .halted     (halted)
  );

  tiny9_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .memRdata   (memRdata),
    .inPort     (inPort),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .opcode     (opcode),
    .fieldAddr  (fieldAddr),
    .regNonZero (regNonZero),
    .outPort    (outPort),
    .outStrobe  (outStrobe)
  );

  assign memWe = ctl.memWe;
endmodule

// File: tb/sim_tiny9_cpu.sv
`timescale 1ns/1ps
module sim_tiny9_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] memAddr;
  logic       memWe;
  logic [8:0] memWdata, memRdata, inPort, outPort;
  logic       outStrobe, halted;

  int testCnt = 0;
  int failCnt = 0;

  logic [8:0] mem     [16];
  logic [8:0] progMem [16];
  logic [8:0] mdlMem  [16];
  logic [8:0] capOut  [64];
  int         capCnt = 0;
  logic [8:0] expOut  [64];
  int         expCnt;

  always #4 clk = ~clk;

  tiny9_cpu u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .inPort(inPort), .outPort(outPort),
    .outStrobe(outStrobe), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWe === 1'b1) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (!rst && outStrobe === 1'b1 && capCnt < 64) begin
      capOut[capCnt] = outPort;
      capCnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] mk(input logic [2:0] op, input logic [1:0] r, input logic [3:0] f);
    return {op, r, f};
  endfunction

  // ISA-level reference built from R2..R9
  task automatic model(input logic [8:0] inVal);
    logic [8:0] r [4];
    logic [3:0] pc;
    logic [8:0] w;
    for (int i = 0; i < 4; i++) r[i] = '0;
    pc = '0;
    expCnt = 0;
    for (int step = 0; step < 200; step++) begin
      w = mdlMem[pc];
      if (w == '0) break;
      case (w[8:6])
        3'b000: begin r[w[5:4]] = r[w[3:2]] - r[w[1:0]]; pc = pc + 1'b1; end
        3'b001: begin r[w[5:4]] = r[w[3:2]] + r[w[1:0]]; pc = pc + 1'b1; end
        3'b010: begin r[w[5:4]] = (w[3:0] == 4'd14) ? inVal : mdlMem[w[3:0]]; pc = pc + 1'b1; end
        3'b011: begin
          if (w[3:0] == 4'd15) begin expOut[expCnt] = r[w[5:4]]; expCnt++; end
          else mdlMem[w[3:0]] = r[w[5:4]];
          pc = pc + 1'b1;
        end
        3'b100: begin r[w[5:4]] = inVal; pc = pc + 1'b1; end
        3'b101: begin expOut[expCnt] = r[w[5:4]]; expCnt++; pc = pc + 1'b1; end
        3'b110: pc = w[3:0];
        default: pc = (r[w[5:4]] != '0) ? w[3:0] : pc + 1'b1;
      endcase
    end
  endtask

  task automatic runProgram(input logic [8:0] inVal, input string tag);
    int cyc;
    rst = 1'b1;
    inPort = inVal;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      mem[i] = progMem[i];
      mdlMem[i] = progMem[i];
    end
    capCnt = 0;
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (halted !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted === 1'b1, {tag, " R9 halt reached"}, int'(halted), 1);
    model(inVal);
    chk(capCnt == expCnt, {tag, " R6 output count"}, capCnt, expCnt);
    for (int i = 0; i < expCnt && i < capCnt; i++)
      chk(capOut[i] == expOut[i], {tag, " R2 R3 output value"}, capOut[i], expOut[i]);
    for (int i = 0; i < 16; i++)
      chk(mem[i] == mdlMem[i], {tag, " R4 R5 memory word"}, mem[i], mdlMem[i]);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) progMem[i] = '0;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    inPort = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;

    // R1: port state while held in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(memAddr == 4'd0, "R1 reset memAddr", memAddr, 0);
    chk(halted === 1'b0, "R1 reset halted", int'(halted), 0);
    chk(outStrobe === 1'b0, "R1 reset outStrobe", int'(outStrobe), 0);
    chk(memWe === 1'b0, "R1 reset memWe", int'(memWe), 0);

    // R3 R4 R5 R6: worked example relocated (data at 10, result at 11)
    clearProg();
    progMem[0] = mk(3'b010, 2'd2, 4'd10);
    progMem[1] = mk(3'b100, 2'd3, 4'd14);
    progMem[2] = 9'b000_01_11_10;
    progMem[3] = mk(3'b011, 2'd1, 4'd11);
    progMem[4] = mk(3'b101, 2'd1, 4'd0);
    progMem[10] = 9'd5;
    runProgram(9'd7, "example");
    chk(capCnt == 1 && capOut[0] == 9'd2, "R3 R6 sub 7-5", capOut[0], 2);
    chk(mem[11] == 9'd2, "R5 store to memory", mem[11], 2);

    // R3: modulo-512 wrap and R0 as ordinary register
    clearProg();
    progMem[0] = mk(3'b010, 2'd1, 4'd13);
    progMem[1] = mk(3'b010, 2'd2, 4'd12);
    progMem[2] = 9'b001_11_01_10;
    progMem[3] = mk(3'b101, 2'd3, 4'd0);
    progMem[4] = 9'b000_00_10_01;
    progMem[5] = mk(3'b101, 2'd0, 4'd0);
    progMem[12] = 9'd1;
    progMem[13] = 9'h1FF;
    runProgram(9'd0, "wrap");
    chk(capOut[0] == 9'd0, "R3 add wraps to 0", capOut[0], 0);
    chk(capOut[1] == 9'd2, "R3 sub wraps into R0", capOut[1], 2);

    // R1: registers cleared by reset (previous run left them non-zero)
    clearProg();
    for (int k = 0; k < 4; k++) progMem[k] = mk(3'b101, 2'(k), 4'd9);
    runProgram(9'h155, "regreset");
    for (int k = 0; k < 4; k++)
      chk(capCnt == 4 && capOut[k] == 9'd0, "R1 register cleared", capOut[k], 0);

    // R4 R5: port-mapped addresses 14 and 15
    clearProg();
    progMem[0] = mk(3'b010, 2'd1, 4'd14);
    progMem[1] = mk(3'b011, 2'd1, 4'd15);
    progMem[2] = mk(3'b011, 2'd1, 4'd14);
    progMem[14] = 9'h044;
    progMem[15] = 9'h033;
    runProgram(9'h0A5, "ports");
    chk(capCnt == 1 && capOut[0] == 9'h0A5, "R4 R5 load14 store15", capOut[0], 9'h0A5);
    chk(mem[15] == 9'h033, "R5 address 15 not written", mem[15], 9'h033);
    chk(mem[14] == 9'h0A5, "R5 store to 14 hits memory", mem[14], 9'h0A5);

    // R7 R8: branch not taken, jump to 15, counter wraps, branch taken
    clearProg();
    progMem[0]  = mk(3'b111, 2'd2, 4'd5);
    progMem[1]  = mk(3'b100, 2'd2, 4'd0);
    progMem[2]  = mk(3'b110, 2'd0, 4'd15);
    progMem[3]  = mk(3'b101, 2'd2, 4'd0);
    progMem[15] = mk(3'b101, 2'd2, 4'd3);
    runProgram(9'h101, "flow");
    chk(capCnt == 1, "R7 R8 jump skips word 3", capCnt, 1);
    chk(capOut[0] == 9'h101, "R8 wrap 15 to 0 then branch taken", capOut[0], 9'h101);

    // R9: stays halted and quiet
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(halted === 1'b1 && memWe === 1'b0 && outStrobe === 1'b0,
          "R9 halted quiet", int'(halted), 1);
    end
    chk(capCnt == 1, "R9 no output after halt", capCnt, 1);

    // R2..R8: constrained random programs, forward-only control flow
    for (int p = 0; p < 40; p++) begin
      clearProg();
      for (int i = 0; i < 8; i++) begin
        logic [2:0] op;
        logic [3:0] f;
        op = 3'($urandom % 8);
        f  = 4'($urandom % 16);
        if (op == 3'b110 || op == 3'b111) f = 4'(i + 1 + ($urandom % (8 - i)));
        if (op == 3'b011) f = ($urandom % 2) ? 4'd13 : 4'd15;
        progMem[i] = mk(op, 2'($urandom % 4), f);
      end
      for (int k = 0; k < 4; k++) progMem[8 + k] = mk(3'b101, 2'(k), 4'($urandom % 16));
      progMem[12] = '0;
      progMem[13] = 9'($urandom);
      progMem[14] = 9'($urandom);
      progMem[15] = 9'($urandom);
      runProgram(9'($urandom), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule